// File: doc/BRIEF.md
# Soft-Ramp Zero-Cross Gain Controller

This block decides, cycle by cycle, which gain a two-channel audio gain stage should apply. Each channel has a 6-bit two's complement gain request in half-decibel steps and a mute request. The block turns these into a target level and moves the applied level toward it. A two-bit mode picks how the level moves: it can jump at once, ramp in eighth-decibel steps, jump only at a zero crossing of that channel's signal, or ramp with each step waiting for a zero crossing.

The block watches one signed sample per channel on every frame strobe, which marks one left/right frame. It uses those samples to find zero crossings. When zero-cross gating is on and no crossing comes, a frame counter forces the pending change after a fixed number of frames. Each channel's output is a signed control word in eighth-decibel units plus a muted flag. The word feeds an analog gain stage that is outside this block.

Top module: `gain_ramp_ctl`

## Requirements
- R1: The level output is a signed two's complement value in 1/8 dB units. For an in-range request code c (-24..24, 0.5 dB per LSB), the settled level is 4*c. Code 000000 gives level 0, 011000 gives 96 and 101000 gives -96.
- R2: A request code above 24 acts as 24, and a code below -24 acts as -24. Apart from the mute level, the level never leaves -96..96.
- R3: With soft ramp on and zero-cross off, the level moves by exactly one unit toward the target on each frame strobe. It does not change in cycles without a strobe.
- R4: With zero-cross on and soft ramp off, a pending change to the full target happens only on a strobe whose sample is zero, or whose sign bit differs from the previous strobed sample of that channel.
- R5: With zero-cross on, if the TO_FRAMES-th strobe since a step became pending brings no crossing, the step is applied on that strobe anyway. The counter restarts after every applied step.
- R6: Each channel keeps its own crossing history, timeout count and level. An event on one channel never moves the other.
- R7: With soft ramp and zero-cross both on, each single one-unit step needs its own crossing or its own timeout.
- R8: Mute makes the target -97, which is 1/8 dB below the lowest gain. The muted output is 1 exactly when the level equals -97. Mute and unmute follow the same mode rules as a gain change.
- R9: With both mode bits clear, the level equals the target one clock after the target is presented.
- R10: If the target changes during a ramp, stepping continues from the present level toward the new target, one unit per allowed step, with no jump.
- R11: After reset, both levels are 0, muted is 0 and the previous sample sign of both channels is taken as non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per frame; samples are valid with it |
| soft_en | input | 1 | Soft ramp enable (mode bit 0) |
| zc_en | input | 1 | Zero-cross gating enable (mode bit 1) |
| mute | input | NCH | Per-channel mute request |
| gain_req | input | NCH x 6 | Per-channel two's complement gain code, 0.5 dB per LSB |
| sample | input | NCH x SW | Per-channel signed sample, sampled on frame_stb |
| level | output | NCH x 8 | Applied level, signed, 1/8 dB per LSB |
| muted | output | NCH | Channel sits at the mute level |

## Verification
The assertions assume that frame_stb is a single-cycle pulse and that samples are only meaningful in a strobe cycle. They also assume that the mode bits and requests are synchronous inputs, which may change on any clock. The bench drives every input half a period away from the rising edge and holds it for whole cycles. It raises frame_stb for one cycle at a time, with idle cycles in between, so both the strobe-paced rules and the per-cycle rules are exercised. Request codes cover all 64 values, so the reserved codes reach the clamp that the range assertion relies on.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;

    localparam int GAIN_W        = 6;
    localparam int LVL_W         = 8;
    localparam int MAX_CODE      = 24;
    localparam int EIGHTHS_PER_C = 4;
    localparam int MAX_LVL_I     = MAX_CODE * EIGHTHS_PER_C;
    localparam int MUTE_LVL_I    = -MAX_LVL_I - 1;

    typedef logic signed [LVL_W-1:0]  lvl_t;
    typedef logic signed [GAIN_W-1:0] code_t;

    localparam lvl_t  MUTE_LVL = lvl_t'(MUTE_LVL_I);
    localparam code_t CODE_HI  = code_t'(MAX_CODE);
    localparam code_t CODE_LO  = code_t'(-MAX_CODE);

    typedef enum logic [1:0] {
        MODE_IMM  = 2'b00,
        MODE_SOFT = 2'b01,
        MODE_ZC   = 2'b10,
        MODE_BOTH = 2'b11
    } mode_e;

    typedef struct packed {
        logic hit;
        logic expire;
    } evt_t;

    function automatic lvl_t code_to_lvl(input code_t code);
        code_t c;
        lvl_t  ext;
        if (code > CODE_HI)
            c = CODE_HI;
        else if (code < CODE_LO)
            c = CODE_LO;
        else
            c = code;
        ext = lvl_t'(c);
        return {ext[LVL_W-3:0], 2'b00};
    endfunction

    function automatic lvl_t step_toward(input lvl_t cur, input lvl_t tgt);
        if (tgt > cur)
            return cur + lvl_t'(1);
        else if (tgt < cur)
            return cur - lvl_t'(1);
        else
            return cur;
    endfunction

endpackage

// File: rtl/gr_zero_cross.sv
module gr_zero_cross #(
    parameter int SW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb,
    input  logic [SW-1:0] sample,
    output logic          hit
);
    logic prev_neg_q;
    logic cur_neg;
    logic is_zero;

    always_comb begin
        cur_neg = sample[SW-1];
        is_zero = (sample == '0);
        hit     = stb && (is_zero || (cur_neg != prev_neg_q));
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev_neg_q <= 1'b0;
        else if (stb)
            prev_neg_q <= cur_neg;
    end
endmodule

// File: rtl/gr_timeout.sv
module gr_timeout #(
    parameter int TO_FRAMES = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic arm,
    input  logic clr,
    output logic expire
);
    localparam int CW = (TO_FRAMES > 2) ? $clog2(TO_FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TO_FRAMES - 1);

    logic [CW-1:0] cnt_q;

    assign expire = arm && stb && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !arm)
            cnt_q <= '0;
        else if (stb)
            cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/gr_level_chan.sv
module gr_level_chan
    import gain_ramp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic soft_en,
    input  logic zc_en,
    input  lvl_t tgt,
    input  evt_t evt,
    output lvl_t lvl,
    output logic pending,
    output logic step
);
    lvl_t  lvl_q;
    lvl_t  nxt;
    logic  fire;
    mode_e mode;

    always_comb begin
        mode    = mode_e'({zc_en, soft_en});
        pending = (lvl_q != tgt);
        case (mode)
            MODE_IMM:  fire = 1'b1;
            MODE_SOFT: fire = stb;
            MODE_ZC,
            MODE_BOTH: fire = evt.hit || evt.expire;
            default:   fire = 1'b0;
        endcase
        step = pending && fire;
        nxt  = soft_en ? step_toward(lvl_q, tgt) : tgt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= '0;
        else if (step)
            lvl_q <= nxt;
    end

    assign lvl = lvl_q;
endmodule

// File: rtl/gain_ramp_ctl.sv
module gain_ramp_ctl
    import gain_ramp_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int SW        = 24,
    parameter int TO_FRAMES = 512
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frame_stb,
    input  logic                        soft_en,
    input  logic                        zc_en,
    input  logic [NCH-1:0]              mute,
    input  logic [NCH-1:0][GAIN_W-1:0]  gain_req,
    input  logic [NCH-1:0][SW-1:0]      sample,
    output logic [NCH-1:0][LVL_W-1:0]   level,
    output logic [NCH-1:0]              muted
);
    logic [NCH-1:0][LVL_W-1:0] tgt_lvl;
    logic [NCH-1:0]            zc_hit;
    logic [NCH-1:0]            to_exp;
    logic [NCH-1:0]            pend;
    logic [NCH-1:0]            stepped;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lvl_t tgt_c;
        lvl_t lvl_c;
        evt_t evt_c;

        assign tgt_c      = mute[c] ? MUTE_LVL : code_to_lvl(code_t'(gain_req[c]));
        assign tgt_lvl[c] = tgt_c;
        assign evt_c      = '{hit: zc_hit[c], expire: to_exp[c]};

        gr_zero_cross #(.SW(SW)) u_zc (
            .clk    (clk),
            .rst    (rst),
            .stb    (frame_stb),
            .sample (sample[c]),
            .hit    (zc_hit[c])
        );

        gr_timeout #(.TO_FRAMES(TO_FRAMES)) u_to (
            .clk    (clk),
            .rst    (rst),
            .stb    (frame_stb),
            .arm    (pend[c] && zc_en),
            .clr    (stepped[c]),
            .expire (to_exp[c])
        );

        gr_level_chan u_lvl (
            .clk     (clk),
            .rst     (rst),
            .stb     (frame_stb),
            .soft_en (soft_en),
            .zc_en   (zc_en),
            .tgt     (tgt_c),
            .evt     (evt_c),
            .lvl     (lvl_c),
            .pending (pend[c]),
            .step    (stepped[c])
        );

        assign level[c] = lvl_c;
        assign muted[c] = (lvl_c == MUTE_LVL);
    end
endmodule

// File: rtl/gain_ramp_ctl_chk.sv
module gain_ramp_ctl_chk
    import gain_ramp_pkg::*;
#(
    parameter int NCH = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      frame_stb,
    input logic                      soft_en,
    input logic                      zc_en,
    input logic [NCH-1:0][LVL_W-1:0] level,
    input logic [NCH-1:0][LVL_W-1:0] tgt_lvl,
    input logic [NCH-1:0]            zc_hit,
    input logic [NCH-1:0]            to_exp
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2 / R8: level stays within the gain range or sits at the mute level
        p_range_r2: assert property (@(posedge clk) disable iff (rst)
            ($signed(level[c]) >= -MAX_LVL_I && $signed(level[c]) <= MAX_LVL_I)
            || $signed(level[c]) == MUTE_LVL_I);

        // R3 / R7: with soft ramp on, one clock moves the level by at most one unit
        p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
            soft_en |=> (level[c] == $past(level[c])
                      || level[c] == $past(level[c]) + LVL_W'(1)
                      || level[c] == $past(level[c]) - LVL_W'(1)));

        // R3: in any paced mode the level holds between frame strobes
        p_hold_no_stb_r3: assert property (@(posedge clk) disable iff (rst)
            ((soft_en || zc_en) && !frame_stb) |=> $stable(level[c]));

        // R4 / R5: with zero-cross on, the level moves only on a crossing or a timeout
        p_zc_gate_r4: assert property (@(posedge clk) disable iff (rst)
            (zc_en && !zc_hit[c] && !to_exp[c]) |=> $stable(level[c]));

        // R9: immediate mode lands on the target one clock later
        p_immediate_r9: assert property (@(posedge clk) disable iff (rst)
            (!soft_en && !zc_en) |=> level[c] == $past(tgt_lvl[c]));
    end
endmodule

bind gain_ramp_ctl gain_ramp_ctl_chk #(.NCH(NCH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .soft_en   (soft_en),
    .zc_en     (zc_en),
    .level     (level),
    .tgt_lvl   (tgt_lvl),
    .zc_hit    (zc_hit),
    .to_exp    (to_exp)
);

// File: tb/gain_ramp_ctl_tb_top.sv
module gain_ramp_ctl_tb_top;
    localparam int NCH = 2;
    localparam int SW  = 24;
    localparam int TOF = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_stb = 1'b0;
    logic soft_en = 1'b0;
    logic zc_en = 1'b0;
    logic [NCH-1:0]         mute = '0;
    logic [NCH-1:0][5:0]    gain_req = '0;
    logic [NCH-1:0][SW-1:0] sample = '0;
    logic [NCH-1:0][7:0]    level;
    logic [NCH-1:0]         muted;

    int n_cmp = 0;
    int n_bad = 0;
    int m_lvl [NCH];
    int m_cnt [NCH];
    bit m_neg [NCH];

    always #2 clk = ~clk;

    gain_ramp_ctl #(.NCH(NCH), .SW(SW), .TO_FRAMES(TOF)) dut_i (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .soft_en(soft_en),
        .zc_en(zc_en), .mute(mute), .gain_req(gain_req), .sample(sample),
        .level(level), .muted(muted)
    );

    function automatic int tgt_of(int ch);
        int c;
        if (mute[ch]) return -97;
        c = int'($signed(gain_req[ch]));
        if (c > 24) c = 24;
        if (c < -24) c = -24;
        return c * 4;
    endfunction

    task automatic chk(string tag, int ch, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: actual=%0d expected=%0d", tag, ch, act, exp);
        end
    endtask

    // Drive one cycle (from a falling edge), advance the model, check at the next falling edge.
    task automatic cyc(bit stb, int sa, int sb, string tag);
        int  s, t, ev_hit;
        bit  pend, fire, expire;
        frame_stb = stb;
        sample[0] = SW'(sa);
        sample[1] = SW'(sb);
        for (int ch = 0; ch < NCH; ch++) begin
            s      = (ch == 0) ? sa : sb;
            t      = tgt_of(ch);
            pend   = (m_lvl[ch] != t);
            ev_hit = stb && (s == 0 || ((s < 0) != m_neg[ch]));
            expire = stb && pend && zc_en && (m_cnt[ch] == TOF - 1);
            if (zc_en)        fire = (ev_hit != 0) || expire;
            else if (soft_en) fire = stb;
            else              fire = 1'b1;
            if (pend && fire) begin
                if (soft_en) m_lvl[ch] = m_lvl[ch] + ((t > m_lvl[ch]) ? 1 : -1);
                else         m_lvl[ch] = t;
                m_cnt[ch] = 0;
            end else if (!(pend && zc_en)) begin
                m_cnt[ch] = 0;
            end else if (stb) begin
                m_cnt[ch] = m_cnt[ch] + 1;
            end
            if (stb) m_neg[ch] = (s < 0);
        end
        @(posedge clk);
        @(negedge clk);
        frame_stb = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            chk(tag, ch, int'($signed(level[ch])), m_lvl[ch]);
            chk("R8", ch, int'(muted[ch]), int'(m_lvl[ch] == -97));
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int sgn;
        for (int ch = 0; ch < NCH; ch++) begin
            m_lvl[ch] = 0; m_cnt[ch] = 0; m_neg[ch] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R11: reset state
        for (int ch = 0; ch < NCH; ch++) begin
            chk("R11", ch, int'($signed(level[ch])), 0);
            chk("R11", ch, int'(muted[ch]), 0);
        end
        rst = 1'b0;

        // R1 / R2 / R9: all 64 codes in immediate mode, opposite order on the other channel
        for (int code = 0; code < 64; code++) begin
            int sc;
            gain_req[0] = 6'(code);
            gain_req[1] = 6'(63 - code);
            sc = (code > 31) ? code - 64 : code;
            cyc(1'b0, 1, 1, (sc > 24 || sc < -24) ? "R2" : "R1");
            cyc(1'b0, 1, 1, "R9");
        end

        // R3: soft ramp on both channels, idle cycles between strobes
        gain_req[0] = 6'd0; gain_req[1] = 6'd0;
        cyc(1'b0, 1, 1, "R9");
        soft_en = 1'b1;
        gain_req[0] = 6'd24;
        gain_req[1] = 6'b111000;
        for (int i = 0; i < 40; i++) begin
            cyc(1'b1, 5, 5, "R3");
            cyc(1'b0, 5, 5, "R3");
        end
        // R10: redirect mid-ramp
        gain_req[0] = 6'b111100;
        for (int i = 0; i < 70; i++) begin
            cyc(1'b1, 5, 5, "R10");
            cyc(1'b0, 5, 5, "R10");
        end

        // R8: soft mute and unmute on channel 1 only
        mute[1] = 1'b1;
        for (int i = 0; i < 80; i++) cyc(1'b1, 5, 5, "R8");
        mute[1] = 1'b0;
        for (int i = 0; i < 70; i++) cyc(1'b1, 5, 5, "R8");

        // R4 / R6: zero-cross gating, full jumps
        soft_en = 1'b0;
        gain_req[0] = 6'd0; gain_req[1] = 6'd0;
        cyc(1'b0, 5, 5, "R9");
        zc_en = 1'b1;
        gain_req[0] = 6'd10;
        gain_req[1] = 6'b110110;
        for (int i = 0; i < 5; i++) cyc(1'b1, 7, 7, "R4");
        cyc(1'b1, -3, 9, "R6");
        for (int i = 0; i < 3; i++) cyc(1'b0, -3, 9, "R4");
        // R5: channel 1 never crosses, forced by timeout
        for (int i = 0; i < TOF + 3; i++) cyc(1'b1, -3, 9, "R5");
        // R8 + R4: mute taken on a zero sample
        mute[0] = 1'b1;
        cyc(1'b1, -4, 9, "R8");
        cyc(1'b1, 0, 9, "R8");
        mute[0] = 1'b0;

        // R7: soft ramp with zero-cross; ch0 flips sign every third frame, ch1 relies on timeout
        soft_en = 1'b1;
        gain_req[0] = 6'd4; gain_req[1] = 6'b111100;
        sgn = 1;
        for (int i = 0; i < 200; i++) begin
            if (i % 3 == 0) sgn = -sgn;
            cyc(1'b1, sgn * 11, 9, "R7");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule